// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight level-sensitive interrupt request lines and raises a single interrupt output to a processor. It keeps three 8-bit state words: the pending requests, the levels currently in service, and a software mask. The output is raised when the most urgent unmasked pending request outranks every in-service level that is allowed to block it. A two-strobe acknowledge moves that request into service and then reports its 3-bit level.

Software drives the block through a narrow write/read port. With the address bit high, a write loads the mask and a read returns it. With the address bit low, a write is one of two command words, told apart by bits 4:3. The first kind ends service at a level, either named or implicit, and may rotate the priority order. The second kind selects which word later reads return, switches a special mask mode, and arms a poll. A poll lets software take an interrupt without the acknowledge strobes.

A parameter selects whether service ends automatically on the second acknowledge strobe or only on an explicit end-of-service command.

Top module: `prio_intc`

## Requirements
- R1: After reset the pending, in-service and mask words are all zero. Level 0 ranks highest and level 7 lowest, the interrupt output is low, and a read at address 0 returns the pending word.
- R2: A write at address 1 loads the mask from the data bus. A mask bit of 1 keeps that line from raising the interrupt output. A read at address 1 returns the mask.
- R3: The interrupt output is high exactly when the highest-ranked unmasked pending level ranks strictly above every blocking in-service level. A blocking level is any in-service bit, or in special mask mode only the in-service bits whose level is unmasked.
- R4: An acknowledge strobe in the first phase sets the in-service bit of the winning level and clears its pending bit for one cycle. The next strobe drives that level on vec_o, with vec_valid_o high for that cycle. If no level wins at the first strobe, no in-service bit changes and the second strobe reports level 7.
- R5: A write at address 0 with data bits 4:3 = 00 is a service-end command, and data bits 7:5 give the operation. Code 001 clears the highest-ranked in-service bit. Code 011 clears the in-service bit named by data bits 2:0. With the parameter AUTO_EOI at 0, in-service bits change only through such writes and through acknowledges.
- R6: Code 101 clears the highest-ranked in-service bit and makes that level the lowest rank. Code 111 clears the named level and makes it the lowest rank. Code 110 only makes the named level the lowest rank. The level just above the lowest rank, counting modulo 8, then ranks highest.
- R7: With AUTO_EOI at 1, the in-service bit taken by a granted acknowledge clears on the second strobe. If the rotate-on-automatic flag is set (code 100 sets it, code 000 clears it, and it is clear after reset), that level also becomes the lowest rank.
- R8: A write at address 0 with data bits 4:3 = 01 sets the read selection. Data bits 1:0 = 10 select the pending word, 11 select the in-service word, and 0x leave the selection unchanged.
- R9: In that same command word, data bits 6:5 = 11 enter special mask mode, 10 leave it, and 0x leave it unchanged.
- R10: Data bit 2 = 1 in that command word arms a poll. The next read returns bit 7 = 1 if a level wins, with that level in bits 2:0 (otherwise zero), and has the effect of a first acknowledge strobe on the winner. The read also disarms the poll.
- R11: When a command write and an acknowledge or poll read fall in the same cycle, the in-service bit set by the grant takes precedence over any clear of the same bit. A rotation from the write takes precedence over an automatic rotation.
- R12: Code 010, and writes at address 0 with data bit 4 = 1, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 8 | Level-sensitive interrupt requests |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe (consumes an armed poll) |
| rdata_o | output | 8 | Read data: mask, pending, in-service or poll word |
| ack_i | input | 1 | Acknowledge strobe, two per interrupt |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Level reported on the second acknowledge strobe |
| vec_valid_o | output | 1 | High during the second acknowledge strobe |

## Verification
A service-end or rotation command can arrive in the same clock as an acknowledge strobe. On the first strobe the grant sets an in-service bit while the command clears one. On the second strobe under automatic service end, the command's rotation competes with the automatic rotation. The bench forces both overlaps directly, for example a specific clear of the level being granted, and then keeps provoking them with random streams of writes, reads and strobes. A per-clock model that applies the stated precedence judges every outcome, on one instance built without automatic service end and one built with it.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  typedef enum logic [2:0] {
    OP_ROT_AE_CLR = 3'b000,
    OP_EOI_NS     = 3'b001,
    OP_NOP        = 3'b010,
    OP_EOI_SP     = 3'b011,
    OP_ROT_AE_SET = 3'b100,
    OP_ROT_NS     = 3'b101,
    OP_SET_PRIO   = 3'b110,
    OP_ROT_SP     = 3'b111
  } eoi_op_e;

  typedef struct packed {
    logic    mask_we;
    logic    op_we;
    eoi_op_e op;
    logic [2:0] lvl;
    logic    smm_set;
    logic    smm_clr;
    logic    poll_set;
    logic    sel_we;
    logic    sel_isr;
  } cmd_t;

endpackage

// File: rtl/prio_pick.sv
// Rank of the highest-priority set bit; rank 0 is level low_i+1, N_LVL means none.
module prio_pick #(
  parameter  int unsigned N_LVL = 8,
  localparam int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] vec_i,
  input  logic [LVL_W-1:0] low_i,
  output logic [LVL_W:0]   rank_o
);

  logic [N_LVL-1:0] rot;

  for (genvar g = 0; g < N_LVL; g++) begin : g_rot
    logic [LVL_W-1:0] idx;
    assign idx    = LVL_W'((32'(low_i) + 32'(g) + 32'd1) % N_LVL);
    assign rot[g] = vec_i[idx];
  end

  always_comb begin
    rank_o = (LVL_W+1)'(N_LVL);
    for (int r = N_LVL - 1; r >= 0; r--) begin
      if (rot[r]) rank_o = (LVL_W+1)'(r);
    end
  end

endmodule

// File: rtl/intc_cmd_dec.sv
module intc_cmd_dec
  import prio_intc_pkg::*;
(
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output cmd_t       cmd_o
);

  always_comb begin
    cmd_o     = '0;
    cmd_o.op  = eoi_op_e'(wdata_i[7:5]);
    cmd_o.lvl = wdata_i[2:0];
    if (wr_en_i) begin
      if (addr_i) begin
        cmd_o.mask_we = 1'b1;
      end else if (wdata_i[4:3] == 2'b00) begin
        cmd_o.op_we = 1'b1;
      end else if (wdata_i[4:3] == 2'b01) begin
        cmd_o.smm_set  = (wdata_i[6:5] == 2'b11);
        cmd_o.smm_clr  = (wdata_i[6:5] == 2'b10);
        cmd_o.poll_set = wdata_i[2];
        cmd_o.sel_we   = wdata_i[1];
        cmd_o.sel_isr  = wdata_i[0];
      end
    end
  end

endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             hit_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             phase_o,
  output logic             grant_o,
  output logic             done_o,
  output logic [LVL_W-1:0] lat_o,
  output logic             vec_valid_o
);

  logic             ph_q, hit_q;
  logic [LVL_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b0;
      hit_q <= 1'b0;
      lat_q <= '1;
    end else if (ack_i) begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        lat_q <= hit_i ? lvl_i : '1;  // spurious -> lowest level code
        hit_q <= hit_i;
      end
    end
  end

  assign phase_o     = ph_q;
  assign grant_o     = ack_i & ~ph_q & hit_i;
  assign done_o      = ack_i & ph_q & hit_q;
  assign vec_valid_o = ack_i & ph_q;
  assign lat_o       = lat_q;

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter  int unsigned N_LVL    = 8,
  parameter  bit          AUTO_EOI = 1'b0,
  localparam int unsigned LVL_W    = $clog2(N_LVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] irq_req_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_en_i,
  output logic [7:0]       rdata_o,
  input  logic             ack_i,
  output logic             int_o,
  output logic [LVL_W-1:0] vec_o,
  output logic             vec_valid_o
);

  localparam logic [LVL_W:0] RANK_NONE = (LVL_W+1)'(N_LVL);

  function automatic logic [N_LVL-1:0] bit_of(input logic [LVL_W-1:0] l);
    bit_of    = '0;
    bit_of[l] = 1'b1;
  endfunction

  function automatic logic [LVL_W-1:0] rank2lvl(input logic [LVL_W:0] rk,
                                                input logic [LVL_W-1:0] low);
    return LVL_W'((32'(low) + 32'(rk) + 32'd1) % N_LVL);
  endfunction

  logic [N_LVL-1:0] irr_q, isr_q, imr_q;
  logic [LVL_W-1:0] low_q;
  logic             smm_q, sel_isr_q, poll_q, rae_q;

  cmd_t cmd;

  intc_cmd_dec u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  // Resolution
  logic [N_LVL-1:0] pend, blk;
  logic [LVL_W:0]   req_rk, blk_rk, top_rk;
  logic             win_hit, top_hit;
  logic [LVL_W-1:0] win_lvl, top_lvl;

  assign pend = irr_q & ~imr_q;
  assign blk  = smm_q ? (isr_q & ~imr_q) : isr_q;

  prio_pick #(.N_LVL(N_LVL)) u_req (.vec_i(pend),  .low_i(low_q), .rank_o(req_rk));
  prio_pick #(.N_LVL(N_LVL)) u_blk (.vec_i(blk),   .low_i(low_q), .rank_o(blk_rk));
  prio_pick #(.N_LVL(N_LVL)) u_top (.vec_i(isr_q), .low_i(low_q), .rank_o(top_rk));

  assign win_hit = req_rk < blk_rk;
  assign win_lvl = rank2lvl(req_rk, low_q);
  assign top_hit = top_rk != RANK_NONE;
  assign top_lvl = rank2lvl(top_rk, low_q);

  // Acknowledge
  logic             grant, done, ack_ph;
  logic [LVL_W-1:0] lat_lvl;

  intc_ack_seq #(.LVL_W(LVL_W)) u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .hit_i       (win_hit),
    .lvl_i       (win_lvl),
    .phase_o     (ack_ph),
    .grant_o     (grant),
    .done_o      (done),
    .lat_o       (lat_lvl),
    .vec_valid_o (vec_valid_o)
  );

  logic             poll_rd, aeoi_fire;
  logic [N_LVL-1:0] take, ae_clr, eoi_clr;
  logic             rot_we;
  logic [LVL_W-1:0] rot_lvl;

  assign poll_rd   = rd_en_i & poll_q;
  assign take      = ((grant || (poll_rd && win_hit)) ? bit_of(win_lvl) : '0);
  assign aeoi_fire = AUTO_EOI & done;
  assign ae_clr    = aeoi_fire ? bit_of(lat_lvl) : '0;

  always_comb begin
    eoi_clr = '0;
    rot_we  = 1'b0;
    rot_lvl = cmd.lvl[LVL_W-1:0];
    if (cmd.op_we) begin
      unique case (cmd.op)
        OP_EOI_NS: if (top_hit) eoi_clr = bit_of(top_lvl);
        OP_ROT_NS: if (top_hit) begin
          eoi_clr = bit_of(top_lvl);
          rot_we  = 1'b1;
          rot_lvl = top_lvl;
        end
        OP_EOI_SP: eoi_clr = bit_of(cmd.lvl[LVL_W-1:0]);
        OP_ROT_SP: begin
          eoi_clr = bit_of(cmd.lvl[LVL_W-1:0]);
          rot_we  = 1'b1;
        end
        OP_SET_PRIO: rot_we = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '0;
      low_q     <= LVL_W'(N_LVL - 1);
      smm_q     <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
      rae_q     <= 1'b0;
    end else begin
      irr_q <= irq_req_i & ~take;
      isr_q <= (isr_q & ~(eoi_clr | ae_clr)) | take;  // grant wins over clear
      if (cmd.mask_we) imr_q <= wdata_i[N_LVL-1:0];
      if (rot_we)                     low_q <= rot_lvl;
      else if (aeoi_fire && rae_q)    low_q <= lat_lvl;
      if (cmd.smm_set)      smm_q <= 1'b1;
      else if (cmd.smm_clr) smm_q <= 1'b0;
      if (cmd.sel_we) sel_isr_q <= cmd.sel_isr;
      if (cmd.poll_set)  poll_q <= 1'b1;
      else if (poll_rd)  poll_q <= 1'b0;
      if (cmd.op_we && cmd.op == OP_ROT_AE_SET)      rae_q <= 1'b1;
      else if (cmd.op_we && cmd.op == OP_ROT_AE_CLR) rae_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (poll_q) begin
      rdata_o[7] = win_hit;
      if (win_hit) rdata_o[LVL_W-1:0] = win_lvl;
    end else if (addr_i) begin
      rdata_o[N_LVL-1:0] = imr_q;
    end else begin
      rdata_o[N_LVL-1:0] = sel_isr_q ? isr_q : irr_q;
    end
  end

  assign int_o = win_hit;
  assign vec_o = lat_lvl;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter  int unsigned N_LVL    = 8,
  parameter  bit          AUTO_EOI = 1'b0,
  localparam int unsigned LVL_W    = $clog2(N_LVL)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             addr_i,
  input logic [7:0]       wdata_i,
  input logic             rd_en_i,
  input logic             ack_i,
  input logic             int_o,
  input logic [N_LVL-1:0] irr_q,
  input logic [N_LVL-1:0] isr_q,
  input logic [N_LVL-1:0] imr_q,
  input logic             poll_q,
  input logic             smm_q,
  input logic             ack_ph,
  input logic [LVL_W-1:0] win_lvl
);

  logic ocw3_wr;
  assign ocw3_wr = wr_en_i && !addr_i && wdata_i[4:3] == 2'b01;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i) |=> imr_q == $past(wdata_i[N_LVL-1:0])); // R2

  AST_INT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr_q & ~imr_q) != '0); // R3

  AST_GRANT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_ph && int_o) |=> isr_q[$past(win_lvl)]); // R4

  AST_ISR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (AUTO_EOI == 1'b0 && !wr_en_i) |=> ($past(isr_q) & ~isr_q) == '0); // R5

  AST_SMM_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw3_wr && wdata_i[6:5] == 2'b11) |=> smm_q); // R9

  AST_POLL_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && poll_q && !(ocw3_wr && wdata_i[2])) |=> !poll_q); // R10

endmodule

bind prio_intc prio_intc_chk #(.N_LVL(N_LVL), .AUTO_EOI(AUTO_EOI)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rd_en_i (rd_en_i),
  .ack_i   (ack_i),
  .int_o   (int_o),
  .irr_q   (irr_q),
  .isr_q   (isr_q),
  .imr_q   (imr_q),
  .poll_q  (poll_q),
  .smm_q   (smm_q),
  .ack_ph  (ack_ph),
  .win_lvl (win_lvl)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] rq = '0;
  logic       wr_v = 1'b0, a_v = 1'b0, rd_v = 1'b0, ak_v = 1'b0;
  logic [7:0] d_v = '0;

  logic [7:0] rd_w  [2];
  logic       int_w [2];
  logic [2:0] vec_w [2];
  logic       vv_w  [2];

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done_run = 1'b0;

  always #2 clk = ~clk;

  prio_intc #(.AUTO_EOI(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_req_i(rq), .wr_en_i(wr_v), .addr_i(a_v),
    .wdata_i(d_v), .rd_en_i(rd_v), .rdata_o(rd_w[0]), .ack_i(ak_v),
    .int_o(int_w[0]), .vec_o(vec_w[0]), .vec_valid_o(vv_w[0]));

  prio_intc #(.AUTO_EOI(1'b1)) dut_ae (
    .clk_i(clk), .rst_ni(rst_ni), .irq_req_i(rq), .wr_en_i(wr_v), .addr_i(a_v),
    .wdata_i(d_v), .rd_en_i(rd_v), .rdata_o(rd_w[1]), .ack_i(ak_v),
    .int_o(int_w[1]), .vec_o(vec_w[1]), .vec_valid_o(vv_w[1]));

  // Behavioural reference: index 0 = no automatic end, index 1 = automatic end
  logic [7:0] m_irr [2], m_isr [2], m_imr [2];
  int         m_low [2], m_lat [2];
  bit         m_smm [2], m_sel [2], m_poll [2], m_ph [2], m_hit [2], m_rae [2];

  function automatic int top_of(input logic [7:0] v, input int low);
    for (int r = 1; r <= 8; r++) begin
      int l = (low + r) % 8;
      if (v[l]) return l;
    end
    return -1;
  endfunction

  function automatic int rank_of(input int l, input int low);
    return (l - low + 7) % 8;
  endfunction

  function automatic int win_of(input int k);
    int l, bl;
    logic [7:0] b;
    l = top_of(m_irr[k] & ~m_imr[k], m_low[k]);
    if (l < 0) return -1;
    b  = m_smm[k] ? (m_isr[k] & ~m_imr[k]) : m_isr[k];
    bl = top_of(b, m_low[k]);
    if (bl >= 0 && rank_of(bl, m_low[k]) <= rank_of(l, m_low[k])) return -1;
    return l;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int w, t, nlow, lv;
      logic [7:0] set_m, clr_m;
      if (!rst_ni) begin
        m_irr[k] = '0; m_isr[k] = '0; m_imr[k] = '0; m_low[k] = 7; m_lat[k] = 7;
        m_smm[k] = 0; m_sel[k] = 0; m_poll[k] = 0; m_ph[k] = 0; m_hit[k] = 0; m_rae[k] = 0;
      end else begin
        w = win_of(k); t = top_of(m_isr[k], m_low[k]); nlow = m_low[k];
        set_m = '0; clr_m = '0;
        if (ak_v) begin
          if (!m_ph[k]) begin
            if (w >= 0) begin set_m[w] = 1'b1; m_lat[k] = w; m_hit[k] = 1; end
            else begin m_lat[k] = 7; m_hit[k] = 0; end
            m_ph[k] = 1;
          end else begin
            m_ph[k] = 0;
            if (k == 1 && m_hit[k]) begin
              clr_m[m_lat[k]] = 1'b1;
              if (m_rae[k]) nlow = m_lat[k];
            end
          end
        end
        if (rd_v && m_poll[k]) begin
          m_poll[k] = 0;
          if (w >= 0) set_m[w] = 1'b1;
        end
        if (wr_v) begin
          lv = int'(d_v[2:0]);
          if (a_v) m_imr[k] = d_v;
          else if (d_v[4:3] == 2'b00) begin
            case (d_v[7:5])
              3'b001: if (t >= 0) clr_m[t] = 1'b1;
              3'b101: if (t >= 0) begin clr_m[t] = 1'b1; nlow = t; end
              3'b011: clr_m[lv] = 1'b1;
              3'b111: begin clr_m[lv] = 1'b1; nlow = lv; end
              3'b110: nlow = lv;
              3'b100: m_rae[k] = 1;
              3'b000: m_rae[k] = 0;
              default: ;
            endcase
          end else if (d_v[4:3] == 2'b01) begin
            if (d_v[6:5] == 2'b11) m_smm[k] = 1;
            if (d_v[6:5] == 2'b10) m_smm[k] = 0;
            if (d_v[2]) m_poll[k] = 1;
            if (d_v[1:0] == 2'b10) m_sel[k] = 0;
            if (d_v[1:0] == 2'b11) m_sel[k] = 1;
          end
        end
        m_isr[k] = (m_isr[k] & ~clr_m) | set_m;
        m_irr[k] = rq & ~set_m;
        m_low[k] = nlow;
      end
    end
  end

  task automatic chk(input string what, input int k, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%0h expected=%0h", cur_req, what, k, act, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 2; k++) begin
      int w;
      logic [7:0] e;
      w = win_of(k);
      chk("int_o", k, {7'd0, int_w[k]}, {7'd0, w >= 0});
      chk("vec_valid_o", k, {7'd0, vv_w[k]}, {7'd0, ak_v && m_ph[k]});
      if (ak_v && m_ph[k]) chk("vec_o", k, {5'd0, vec_w[k]}, 8'(m_lat[k]));
      if (rd_v) begin
        if (m_poll[k])  e = {w >= 0, 4'b0, (w >= 0) ? 3'(w) : 3'b0};
        else if (a_v)   e = m_imr[k];
        else            e = m_sel[k] ? m_isr[k] : m_irr[k];
        chk("rdata_o", k, rd_w[k], e);
      end
    end
  endtask

  task automatic cyc(input logic w, input logic a, input logic [7:0] d, input logic r, input logic k);
    @(negedge clk);
    wr_v = w; a_v = a; d_v = d; rd_v = r; ak_v = k;
    #1 check_all();
  endtask

  task automatic idle();                        cyc(0, 0, 8'h00, 0, 0); endtask
  task automatic wr(input logic a, input logic [7:0] d); cyc(1, a, d, 0, 0); endtask
  task automatic rd(input logic a);             cyc(0, a, 8'h00, 1, 0); endtask
  task automatic ack2();                        cyc(0, 0, 8'h00, 0, 1); cyc(0, 0, 8'h00, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    cur_req = "R1";
    rd(0); rd(1); idle();
    // R2: mask load and readback
    cur_req = "R2";
    wr(1, 8'hF0); rq = 8'h90; idle(); idle(); rd(1);
    rq = 8'h94; idle(); idle();
    // R3: resolution without blocking
    cur_req = "R3";
    wr(1, 8'h00); rq = 8'h24; idle(); idle();
    // R4: acknowledge pair and nesting
    cur_req = "R4";
    ack2(); idle(); rq = 8'h26; idle(); idle();
    ack2(); rq = 8'h20; idle(); idle();
    // R8: read select
    cur_req = "R8";
    wr(0, 8'h0B); rd(0); wr(0, 8'h08); rd(0); wr(0, 8'h0A); rd(0);
    // R5: non-specific and specific end of service
    cur_req = "R5";
    wr(0, 8'h0B); wr(0, 8'h20); rd(0); wr(0, 8'h62); rd(0); idle();
    // R6: rotations
    cur_req = "R6";
    rq = 8'h00; wr(0, 8'hC3); rq = 8'h11; idle(); idle();
    ack2(); wr(0, 8'hA0); idle(); idle();
    ack2(); wr(0, 8'hE0); idle(); rd(0);
    // R7: automatic end with rotation flag
    cur_req = "R7";
    wr(0, 8'h80); rq = 8'h03; idle(); ack2(); idle(); rd(0);
    ack2(); idle(); rd(0); wr(0, 8'h00); ack2(); idle();
    for (int i = 0; i < 8; i++) wr(0, 8'h20);
    // R9: special mask mode
    cur_req = "R9";
    wr(0, 8'hC7); rq = 8'h04; idle(); ack2(); wr(1, 8'h04); rq = 8'h0C; idle(); idle();
    wr(0, 8'h68); idle(); idle(); ack2(); rd(0);
    wr(0, 8'h48); idle(); idle(); wr(1, 8'h00);
    for (int i = 0; i < 8; i++) wr(0, 8'h20);
    // R10: poll
    cur_req = "R10";
    rq = 8'h40; wr(0, 8'h0C); rd(0); rd(0); idle();
    rq = 8'h00; wr(0, 8'h0C); idle(); rd(0); rd(0);
    for (int i = 0; i < 8; i++) wr(0, 8'h20);
    // R12: no-op and ignored writes; spurious acknowledge
    cur_req = "R12";
    rq = 8'h08; idle(); wr(0, 8'h40); wr(0, 8'h17); wr(0, 8'hFF); rd(0); rd(1);
    rq = 8'h00; idle(); idle(); ack2(); wr(0, 8'h0B); rd(0); wr(0, 8'h0A);
    // R11: same-cycle command and acknowledge
    cur_req = "R11";
    rq = 8'h02; idle(); idle();
    cyc(1, 0, 8'h61, 0, 1); cyc(1, 0, 8'hE5, 0, 1); wr(0, 8'h0B); rd(0);
    wr(0, 8'h80); rq = 8'h08; idle(); idle();
    cyc(1, 0, 8'h20, 0, 1); cyc(1, 0, 8'hC6, 0, 1); idle(); rd(0);
    rq = 8'h10; idle(); wr(0, 8'h0C); cyc(1, 0, 8'h20, 1, 1); cyc(0, 0, 8'h00, 0, 1); rd(0);
    for (int i = 0; i < 600; i++) begin
      logic w, a, r, k;
      logic [7:0] d;
      w = ($urandom % 5) == 0;
      a = ($urandom % 4) == 0;
      r = ($urandom % 4) == 0;
      k = ($urandom % 3) == 0;
      d = 8'($urandom);
      if (($urandom % 8) == 0) rq = 8'($urandom);
      cyc(w, a, d, r, k);
    end
    idle();
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule